// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits beside a receive MAC and decides, for every incoming frame, whether the frame is to be kept. The destination address arrives one byte per valid cycle, in wire order, starting with the first byte of each frame; the block captures the first six bytes, compares them with the local station address, classifies them as unicast, multicast or broadcast, and folds them into a serial CRC-32 whose top six bits pick one of 64 bins in a multicast hash table. When the MAC strobes the end of the frame, together with the frame length and its CRC and alignment error flags, the block applies the receive control bits and delivers a registered verdict one cycle later.

A side function lets another station on the network switch this node's transmitter off and back on: when remote transmit control is enabled, a group address that lands in bin 62 produces a disable pulse and one that lands in bin 63 produces an enable pulse. The pulses are meant for the transmit controller, which keeps the on/off state itself.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset all outputs are 0. The verdict outputs (res_valid, accept, group_flag, tx_off_pulse, tx_on_pulse) change only in the cycle after a frame_end strobe; res_valid is 1 for exactly that one cycle and 0 otherwise.
- R2: The address is taken from the first six byte_vld cycles since reset or since the last frame_end; byte 0 is the first received and is compared with station_addr[7:0], byte 5 with station_addr[47:40]. Further bytes before frame_end have no effect; a frame that ended with fewer than six bytes is rejected in every configuration.
- R3: A unicast address (bit 0 of byte 0 equal to 0) is accepted when it equals station_addr, or for any value when rx_cfg bit 4 (promiscuous) is 1.
- R4: The broadcast address (all 48 bits 1) is accepted only when rx_cfg bit 2 is 1, independently of the hash table.
- R5: A non-broadcast group address is accepted only when rx_cfg bit 3 is 1 and hash_bits[idx] is 1, where idx is bits 31..26 of a CRC-32 register (polynomial 0x04C11DB7, preset to all ones, no final inversion) shifted MSB-first with the address bits fed least significant bit of each byte first, bytes in received order.
- R6: A frame whose frame_len is below 64 is rejected unless rx_cfg bit 1 is 1; a length of exactly 64 is not a runt.
- R7: A frame with crc_err or align_err set is rejected unless rx_cfg bit 0 is 1.
- R8: When rx_cfg bit 5 (monitor) is 1, accept is 0 whatever the other inputs.
- R9: group_flag is 1 for a complete address whose byte 0 has bit 0 set (multicast or broadcast) and 0 for unicast, regardless of the accept decision.
- R10: With auto_tx_ctl_en at 1, a complete non-broadcast group address with idx 62 gives a one-cycle tx_off_pulse and one with idx 63 a one-cycle tx_on_pulse, regardless of rx_cfg, hash_bits, length and error flags; with auto_tx_ctl_en at 0 neither pulse occurs, and the two never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cfg | input | 6 | Receive controls: 0 keep errored, 1 keep runts, 2 take broadcast, 3 take multicast, 4 promiscuous, 5 monitor |
| auto_tx_ctl_en | input | 1 | Enables remote transmitter control through hash bins 62 and 63 |
| station_addr | input | 48 | Local station address, first wire byte in bits 7..0 |
| hash_bits | input | 64 | Multicast hash table, bin n in bit n |
| byte_vld | input | 1 | byte_in carries a received byte |
| byte_in | input | 8 | Received byte |
| frame_end | input | 1 | One-cycle end-of-frame strobe |
| frame_len | input | 16 | Frame length in bytes, valid with frame_end |
| crc_err | input | 1 | Frame had a CRC error, valid with frame_end |
| align_err | input | 1 | Frame had an alignment error, valid with frame_end |
| res_valid | output | 1 | Verdict valid (cycle after frame_end) |
| accept | output | 1 | Frame is to be kept |
| group_flag | output | 1 | 1 for a group address, 0 for unicast |
| tx_off_pulse | output | 1 | Remote request to disable the transmitter |
| tx_on_pulse | output | 1 | Remote request to enable the transmitter |

## Verification
The bench builds the block with its default parameters: six address bytes, a 64-byte runt limit and a six-bit hash index, so the table has 64 bins and the remote control bins are 62 and 63. With these values the runt boundary at lengths 63 and 64 is driven directly, and the bench searches a few thousand group addresses with its own CRC model to land one in a chosen bin, in bin 62 and in bin 63, which makes single-bin hash selection and both transmitter control pulses reachable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // receive control word, member listed last sits in bit 0
  typedef struct packed {
    logic monitor;     // bit 5
    logic promisc;     // bit 4
    logic take_mcast;  // bit 3
    logic take_bcast;  // bit 2
    logic take_runt;   // bit 1
    logic keep_bad;    // bit 0
  } rx_cfg_t;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // one byte into the running CRC, least significant data bit first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] cur,
                                                input logic [7:0]  din);
    logic [31:0] c;
    logic        fb;
    c = cur;
    for (int k = 0; k < 8; k++) begin
      fb = c[31] ^ din[k];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  input  logic                    frame_end,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic                    addr_done,
  output logic [HASH_W-1:0]       hash_idx
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      crc_q;
  logic             take;

  assign take      = byte_vld && (cnt_q != CNT_FULL);
  assign addr_done = (cnt_q == CNT_FULL);
  assign hash_idx  = crc_q[31 -: HASH_W];

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      crc_q <= crc_step_byte(crc_q, byte_in);
    end
  end

  // one register lane per address byte
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || frame_end) addr_q[8*g +: 8] <= '0;
      else if (take && cnt_q == CNT_W'(g)) addr_q[8*g +: 8] <= byte_in;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

  a_r2_extra_bytes_ignored: assert property (@(posedge clk) disable iff (rst)
    addr_done && !frame_end |=> $stable(addr_q) && $stable(crc_q));

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int BIN_OFF    = 62,
  parameter int BIN_ON     = 63
) (
  input  logic [8*ADDR_BYTES-1:0] addr_q,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<HASH_W)-1:0]  hash_bits,
  input  logic [HASH_W-1:0]       hash_idx,
  input  logic                    addr_done,
  input  rx_cfg_t                 cfg,
  output logic                    is_group,
  output logic                    addr_ok,
  output logic                    hit_off,
  output logic                    hit_on
);

  logic [ADDR_BYTES-1:0] lane_eq;
  logic                  is_bcast;
  logic                  own_match;
  logic                  mc_ok;
  logic                  special;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
    assign lane_eq[g] = (addr_q[8*g +: 8] == station_addr[8*g +: 8]);
  end

  assign own_match = &lane_eq;
  assign is_bcast  = &addr_q;
  assign is_group  = addr_done && addr_q[0];
  assign mc_ok     = cfg.take_mcast && hash_bits[hash_idx];

  always_comb begin
    if (!addr_done)     addr_ok = 1'b0;
    else if (!addr_q[0]) addr_ok = cfg.promisc || own_match;
    else if (is_bcast)  addr_ok = cfg.take_bcast;
    else                addr_ok = mc_ok;
  end

  assign special = is_group && !is_bcast;
  assign hit_off = special && (hash_idx == HASH_W'(BIN_OFF));
  assign hit_on  = special && (hash_idx == HASH_W'(BIN_ON));

  a_r10_bins_distinct: assert final (!(hit_off && hit_on));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 64,
  parameter int BIN_OFF    = 62,
  parameter int BIN_ON     = 63
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [5:0]              rx_cfg,
  input  logic                    auto_tx_ctl_en,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<HASH_W)-1:0]  hash_bits,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  input  logic                    frame_end,
  input  logic [LEN_W-1:0]        frame_len,
  input  logic                    crc_err,
  input  logic                    align_err,
  output logic                    res_valid,
  output logic                    accept,
  output logic                    group_flag,
  output logic                    tx_off_pulse,
  output logic                    tx_on_pulse
);

  localparam logic [LEN_W-1:0] RUNT_LIMIT = LEN_W'(MIN_LEN);

  rx_cfg_t                 cfg;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic                    addr_done;
  logic [HASH_W-1:0]       hash_idx;
  logic                    is_group;
  logic                    addr_ok;
  logic                    hit_off;
  logic                    hit_on;
  logic                    len_ok;
  logic                    err_ok;
  logic                    keep;

  assign cfg = rx_cfg_t'(rx_cfg);

  rxf_capture #(
    .ADDR_BYTES(ADDR_BYTES),
    .HASH_W    (HASH_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .frame_end(frame_end),
    .addr_q   (addr_q),
    .addr_done(addr_done),
    .hash_idx (hash_idx)
  );

  rxf_classify #(
    .ADDR_BYTES(ADDR_BYTES),
    .HASH_W    (HASH_W),
    .BIN_OFF   (BIN_OFF),
    .BIN_ON    (BIN_ON)
  ) u_classify (
    .addr_q      (addr_q),
    .station_addr(station_addr),
    .hash_bits   (hash_bits),
    .hash_idx    (hash_idx),
    .addr_done   (addr_done),
    .cfg         (cfg),
    .is_group    (is_group),
    .addr_ok     (addr_ok),
    .hit_off     (hit_off),
    .hit_on      (hit_on)
  );

  assign len_ok = (frame_len >= RUNT_LIMIT) || cfg.take_runt;
  assign err_ok = !(crc_err || align_err) || cfg.keep_bad;
  assign keep   = addr_ok && len_ok && err_ok && !cfg.monitor;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      accept       <= 1'b0;
      group_flag   <= 1'b0;
      tx_off_pulse <= 1'b0;
      tx_on_pulse  <= 1'b0;
    end else begin
      res_valid    <= frame_end;
      accept       <= frame_end && keep;
      group_flag   <= frame_end && is_group;
      tx_off_pulse <= frame_end && auto_tx_ctl_en && hit_off;
      tx_on_pulse  <= frame_end && auto_tx_ctl_en && hit_on;
    end
  end

  a_r1_verdict_follows_end: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> res_valid);

  a_r1_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> !res_valid && !accept && !group_flag && !tx_off_pulse && !tx_on_pulse);

  a_r6_runt_dropped: assert property (@(posedge clk) disable iff (rst)
    frame_end && (frame_len < RUNT_LIMIT) && !rx_cfg[1] |=> !accept);

  a_r7_bad_dropped: assert property (@(posedge clk) disable iff (rst)
    frame_end && (crc_err || align_err) && !rx_cfg[0] |=> !accept);

  a_r8_monitor_blocks: assert property (@(posedge clk) disable iff (rst)
    frame_end && rx_cfg[5] |=> !accept);

  a_r10_no_remote_ctl: assert property (@(posedge clk) disable iff (rst)
    frame_end && !auto_tx_ctl_en |=> !tx_off_pulse && !tx_on_pulse);

  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tx_off_pulse && tx_on_pulse));

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  rx_cfg;
  logic        auto_tx_ctl_en;
  logic [47:0] station_addr;
  logic [63:0] hash_bits;
  logic        byte_vld;
  logic [7:0]  byte_in;
  logic        frame_end;
  logic [15:0] frame_len;
  logic        crc_err;
  logic        align_err;
  logic        res_valid, accept, group_flag, tx_off_pulse, tx_on_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst(rst), .rx_cfg(rx_cfg), .auto_tx_ctl_en(auto_tx_ctl_en),
    .station_addr(station_addr), .hash_bits(hash_bits),
    .byte_vld(byte_vld), .byte_in(byte_in), .frame_end(frame_end),
    .frame_len(frame_len), .crc_err(crc_err), .align_err(align_err),
    .res_valid(res_valid), .accept(accept), .group_flag(group_flag),
    .tx_off_pulse(tx_off_pulse), .tx_on_pulse(tx_on_pulse)
  );

  localparam logic [47:0] OWN   = 48'h5544_3322_1102;
  localparam logic [47:0] OTHER = 48'h5544_3322_1104;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h0100_0000_5E01;

  // {addr, cfg, len, crc_err, align_err, exp_accept, exp_group}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {OWN,   6'h00, 16'd64,   1'b0, 1'b0, 1'b1, 1'b0},
    {OTHER, 6'h00, 16'd64,   1'b0, 1'b0, 1'b0, 1'b0},
    {OTHER, 6'h10, 16'd64,   1'b0, 1'b0, 1'b1, 1'b0},
    {BCAST, 6'h00, 16'd100,  1'b0, 1'b0, 1'b0, 1'b1},
    {BCAST, 6'h04, 16'd100,  1'b0, 1'b0, 1'b1, 1'b1},
    {MCAST, 6'h00, 16'd80,   1'b0, 1'b0, 1'b0, 1'b1},
    {MCAST, 6'h08, 16'd80,   1'b0, 1'b0, 1'b1, 1'b1},
    {OWN,   6'h00, 16'd63,   1'b0, 1'b0, 1'b0, 1'b0},
    {OWN,   6'h02, 16'd63,   1'b0, 1'b0, 1'b1, 1'b0},
    {OWN,   6'h00, 16'd64,   1'b1, 1'b0, 1'b0, 1'b0},
    {OWN,   6'h01, 16'd64,   1'b0, 1'b1, 1'b1, 1'b0},
    {OWN,   6'h20, 16'd64,   1'b0, 1'b0, 1'b0, 1'b0},
    {BCAST, 6'h0C, 16'd64,   1'b0, 1'b0, 1'b1, 1'b1},
    {OWN,   6'h1F, 16'd1518, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = r[31] ^ a[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r[31:26];
  endfunction

  function automatic logic [47:0] find_group(input logic [5:0] bin);
    for (int b = 0; b < 4096; b++) begin
      logic [47:0] a = {8'(b), 4'h0, 4'(b >> 8), 24'h00_005E, 8'h01};
      if (model_idx(a) == bin) return a;
    end
    return MCAST;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input int nb, input logic [15:0] len,
                      input logic ce, input logic ae);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = (i < 6) ? a[8*i +: 8] : 8'hA5 ^ 8'(i);
    end
    @(negedge clk);
    byte_vld  = 1'b0;
    frame_end = 1'b1;
    frame_len = len;
    crc_err   = ce;
    align_err = ae;
    @(negedge clk);
    frame_end = 1'b0;
    crc_err   = 1'b0;
    align_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] g;
    logic [5:0]  ix;
    rst = 1'b1; rx_cfg = '0; auto_tx_ctl_en = 1'b0; station_addr = OWN;
    hash_bits = '1; byte_vld = 1'b0; byte_in = '0; frame_end = 1'b0;
    frame_len = '0; crc_err = 1'b0; align_err = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({res_valid, accept, group_flag, tx_off_pulse, tx_on_pulse} == 5'b0,
          "R1 reset outputs", {res_valid, accept, group_flag, tx_off_pulse, tx_on_pulse}, 0);
    rst = 1'b0;

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      rx_cfg = VEC[v][25:20];
      send(VEC[v][73:26], 6, VEC[v][19:4], VEC[v][3], VEC[v][2]);
      check(res_valid == 1'b1, $sformatf("R1 valid vec %0d", v), res_valid, 1);
      check(accept == VEC[v][1], $sformatf("R3-R8 accept vec %0d", v), accept, VEC[v][1]);
      check(group_flag == VEC[v][0], $sformatf("R9 group vec %0d", v), group_flag, VEC[v][0]);
      check(!tx_off_pulse && !tx_on_pulse, $sformatf("R10 no pulse vec %0d", v),
            {tx_off_pulse, tx_on_pulse}, 0);
      @(negedge clk);
      check(res_valid == 1'b0, $sformatf("R1 single cycle vec %0d", v), res_valid, 0);
    end

    // R5 single-bin selection
    ix = model_idx(MCAST);
    rx_cfg = 6'h08;
    hash_bits = 64'd1 << ix;
    send(MCAST, 6, 16'd64, 1'b0, 1'b0);
    check(accept == 1'b1, "R5 own bin set", accept, 1);
    hash_bits = ~(64'd1 << ix);
    send(MCAST, 6, 16'd64, 1'b0, 1'b0);
    check(accept == 1'b0, "R5 own bin clear", accept, 0);
    // R4 broadcast ignores the table
    rx_cfg = 6'h04; hash_bits = '0;
    send(BCAST, 6, 16'd64, 1'b0, 1'b0);
    check(accept == 1'b1, "R4 bcast empty table", accept, 1);

    // R2 trailing bytes ignored, short address rejected
    rx_cfg = 6'h00; hash_bits = '1;
    send(OWN, 9, 16'd64, 1'b0, 1'b0);
    check(accept == 1'b1, "R2 extra bytes", accept, 1);
    rx_cfg = 6'h1F;
    send(OTHER, 4, 16'd64, 1'b0, 1'b0);
    check(accept == 1'b0, "R2 short address", accept, 0);
    check(res_valid == 1'b1, "R2 short valid", res_valid, 1);

    // R10 remote transmitter control
    rx_cfg = 6'h00; hash_bits = '0; auto_tx_ctl_en = 1'b1;
    g = find_group(6'd62);
    send(g, 6, 16'd20, 1'b1, 1'b0);
    check(tx_off_pulse == 1'b1 && tx_on_pulse == 1'b0, "R10 bin 62 off",
          {tx_off_pulse, tx_on_pulse}, 2);
    @(negedge clk);
    check(tx_off_pulse == 1'b0, "R10 off one cycle", tx_off_pulse, 0);
    g = find_group(6'd63);
    send(g, 6, 16'd64, 1'b0, 1'b0);
    check(tx_on_pulse == 1'b1 && tx_off_pulse == 1'b0, "R10 bin 63 on",
          {tx_off_pulse, tx_on_pulse}, 1);
    auto_tx_ctl_en = 1'b0;
    send(g, 6, 16'd64, 1'b0, 1'b0);
    check(!tx_on_pulse && !tx_off_pulse, "R10 control disabled",
          {tx_off_pulse, tx_on_pulse}, 0);

    // R1 reset clears a pending verdict
    send(OWN, 6, 16'd64, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check(!res_valid && !accept, "R1 reset mid result", {res_valid, accept}, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule